// File: doc/BRIEF.md
# ECC Error Counting and Reporting Monitor

This block sits behind the ECC checker of a cache data path and decides which of the checker's verdicts become visible to software. On each access that the checker qualifies, it receives a strobe with two flags: one for a single-bit error that was already corrected in the data path, and one for an uncorrectable multi-bit error (double-bit, or several bits inside one nibble). It also receives the address of the access and the syndrome.

Corrected single-bit errors are counted quietly. A report is raised only when the updated count lands exactly on a programmable trigger value. Uncorrectable errors are reported at once whenever their reporting is enabled. So software can let occasional soft faults pass without notice and still get an interrupt for every uncorrectable event. Sticky status bits, an address/syndrome capture of the first reported error, the counter, the trigger and the enables are all reached through a small register port.

Register map (word index on `reg_addr`): 0 control, 1 status, 2 single-bit count, 3 trigger, 4 captured address, 5 captured syndrome. Control bits: bit 0 enables single-bit reporting, bit 1 enables multi-bit reporting, bit 2 enables the single-bit interrupt, bit 3 enables the multi-bit interrupt. Status bits: bit 0 is the single-bit report and bit 1 is the multi-bit report.

Top module: `ecc_err_monitor`

## Requirements
- R1: After reset, every register (control, status, count, trigger, captured address, captured syndrome) reads zero and `irq` is low.
- R2: Each cycle with `chk_valid`=1, `chk_sbe`=1 and `chk_mbe`=0 raises the count (register 2) by one. At its all-ones maximum the count stays put and does not wrap.
- R3: Status bit 0 is set only when the count after the increment equals the trigger (register 3) and control bit 0 is 1. Any other single-bit event leaves status unchanged.
- R4: While the trigger holds zero, no single-bit event ever sets status bit 0, whatever the count.
- R5: A cycle with `chk_valid`=1 and `chk_mbe`=1 sets status bit 1 whenever control bit 1 is 1, independent of the count and the trigger. With control bit 1 at 0, status bit 1 is left unchanged.
- R6: When `chk_sbe` and `chk_mbe` are both 1 in a valid cycle, the event is treated as multi-bit only, and the count is not changed.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: `irq` equals (status bit 0 AND control bit 2) OR (status bit 1 AND control bit 3).
- R9: When a report is raised while both status bits are 0, `chk_addr` is copied into register 4 and `chk_syn` into register 5. While any status bit is set, these registers are not overwritten.
- R10: Writes to registers 0, 2 and 3 take the written value in the next cycle, and reads return it. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | ECC checker result is valid this cycle |
| chk_sbe | input | 1 | Single-bit error seen and corrected |
| chk_mbe | input | 1 | Uncorrectable multi-bit error detected |
| chk_addr | input | ADDR_W | Address of the checked access |
| chk_syn | input | SYN_W | Syndrome of the checked access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Error interrupt |

## Verification
In a single valid cycle the checker can report both a corrected single-bit error and an uncorrectable multi-bit error, so the counting path and the multi-bit reporting path fall in the same cycle. The stimulus table includes one such cycle, placed while the count sits one below the trigger. The checks then confirm that the count did not move, that only the multi-bit status bit rose, and that the capture holds that access's address and syndrome. The next single-bit event must then be the one that reaches the trigger.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL    = 3'd0,
        RA_STATUS  = 3'd1,
        RA_COUNT   = 3'd2,
        RA_TRIG    = 3'd3,
        RA_CAPADDR = 3'd4,
        RA_CAPSYN  = 3'd5
    } reg_sel_e;

    localparam int CTRL_W       = 4;
    localparam int CB_SBE_REP   = 0;
    localparam int CB_MBE_REP   = 1;
    localparam int CB_SBE_IRQ   = 2;
    localparam int CB_MBE_IRQ   = 3;

    localparam int ST_W         = 2;
    localparam int SB_SBE       = 0;
    localparam int SB_MBE       = 1;

endpackage

// File: rtl/ecc_sbe_count.sv
module ecc_sbe_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_cnt_i,
    input  logic             wr_trig_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] trig_o,
    output logic             match_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] trig;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        match_o = 1'b0;
        cnt_inc = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
        if (inc_i) begin
            st_d.cnt = cnt_inc;
            match_o  = (st_q.trig != '0) && (cnt_inc == st_q.trig);
        end
        if (wr_cnt_i)  st_d.cnt  = wdata_i;
        if (wr_trig_i) st_d.trig = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign trig_o = st_q.trig;

    // R2: saturation, no wrap
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i && !wr_cnt_i && (cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX);

    // R2: single step below the limit
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i && !wr_cnt_i && (cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);

    // R4: a zero trigger never matches
    p_trig_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o == '0) |-> !match_o);

endmodule

// File: rtl/ecc_err_latch.sv
module ecc_err_latch
    import ecc_mon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_rep_i,
    input  logic              mbe_rep_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SYN_W-1:0]  syn_i,
    input  logic [ST_W-1:0]   clr_i,
    output logic [ST_W-1:0]   status_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic [SYN_W-1:0]  cap_syn_o
);

    typedef struct packed {
        logic [ST_W-1:0]   status;
        logic [ADDR_W-1:0] cap_addr;
        logic [SYN_W-1:0]  cap_syn;
    } err_state_t;

    err_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.status = st_q.status & ~clr_i;
        if (sbe_rep_i) st_d.status[SB_SBE] = 1'b1;
        if (mbe_rep_i) st_d.status[SB_MBE] = 1'b1;
        if ((sbe_rep_i || mbe_rep_i) && (st_q.status == '0)) begin
            st_d.cap_addr = addr_i;
            st_d.cap_syn  = syn_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o   = st_q.status;
    assign cap_addr_o = st_q.cap_addr;
    assign cap_syn_o  = st_q.cap_syn;

    // R7: sticky single-bit status
    p_sticky_sbe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[SB_SBE] && !clr_i[SB_SBE] |=> status_o[SB_SBE]);

    // R7: sticky multi-bit status
    p_sticky_mbe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[SB_MBE] && !clr_i[SB_MBE] |=> status_o[SB_MBE]);

    // R5: enabled multi-bit report always lands
    p_mbe_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mbe_rep_i |=> status_o[SB_MBE]);

    // R9: capture frozen while a status bit is set
    p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != '0) |=> $stable(cap_addr_o) && $stable(cap_syn_o));

endmodule

// File: rtl/ecc_err_monitor.sv
module ecc_err_monitor
    import ecc_mon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SYN_W  = 8,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              chk_sbe,
    input  logic              chk_mbe,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [SYN_W-1:0]  chk_syn,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              ev_inc, ev_mbe;
    logic              wr_ctrl, wr_cnt, wr_trig, wr_stat;
    logic              sbe_match, sbe_rep, mbe_rep;
    logic [ST_W-1:0]   clr;
    logic [ST_W-1:0]   status;
    logic [CNT_W-1:0]  cnt, trig;
    logic [ADDR_W-1:0] cap_addr;
    logic [SYN_W-1:0]  cap_syn;

    // event qualification: multi-bit wins over single-bit
    assign ev_mbe = chk_valid && chk_mbe;
    assign ev_inc = chk_valid && chk_sbe && !chk_mbe;

    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign wr_stat = reg_we && (reg_addr == RA_STATUS);
    assign wr_cnt  = reg_we && (reg_addr == RA_COUNT);
    assign wr_trig = reg_we && (reg_addr == RA_TRIG);
    assign clr     = wr_stat ? reg_wdata[ST_W-1:0] : '0;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = reg_wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sbe_rep = sbe_match && st_q.ctrl[CB_SBE_REP];
    assign mbe_rep = ev_mbe && st_q.ctrl[CB_MBE_REP];

    ecc_sbe_count #(.CNT_W(CNT_W)) i_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (ev_inc),
        .wr_cnt_i  (wr_cnt),
        .wr_trig_i (wr_trig),
        .wdata_i   (reg_wdata[CNT_W-1:0]),
        .cnt_o     (cnt),
        .trig_o    (trig),
        .match_o   (sbe_match)
    );

    ecc_err_latch #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) i_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sbe_rep_i  (sbe_rep),
        .mbe_rep_i  (mbe_rep),
        .addr_i     (chk_addr),
        .syn_i      (chk_syn),
        .clr_i      (clr),
        .status_o   (status),
        .cap_addr_o (cap_addr),
        .cap_syn_o  (cap_syn)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:    reg_rdata[CTRL_W-1:0] = st_q.ctrl;
            RA_STATUS:  reg_rdata[ST_W-1:0]   = status;
            RA_COUNT:   reg_rdata[CNT_W-1:0]  = cnt;
            RA_TRIG:    reg_rdata[CNT_W-1:0]  = trig;
            RA_CAPADDR: reg_rdata[ADDR_W-1:0] = cap_addr;
            RA_CAPSYN:  reg_rdata[SYN_W-1:0]  = cap_syn;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = (status[SB_SBE] && st_q.ctrl[CB_SBE_IRQ]) ||
                 (status[SB_MBE] && st_q.ctrl[CB_MBE_IRQ]);

    // R6: a cycle flagged as both leaves the count alone
    p_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && chk_sbe && chk_mbe && !wr_cnt |=> $stable(cnt));

    // R3: single-bit status only rises on a trigger match
    p_sbe_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sbe_rep |=> !$rose(status[SB_SBE]));

endmodule

// File: tb/test_ecc_err_monitor.sv
module test_ecc_err_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_valid = 1'b0, chk_sbe = 1'b0, chk_mbe = 1'b0;
    logic [31:0] chk_addr = '0;
    logic [7:0]  chk_syn = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_err_monitor i_ecc_err_monitor (
        .clk(clk), .rst_n(rst_n),
        .chk_valid(chk_valid), .chk_sbe(chk_sbe), .chk_mbe(chk_mbe),
        .chk_addr(chk_addr), .chk_syn(chk_syn),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // entry: {sbe, mbe, addr[7:0], syn[7:0], exp_cnt[7:0], exp_status[1:0]}
    localparam logic [NVEC-1:0][27:0] VEC = {
        {1'b1, 1'b0, 8'h15, 8'h06, 8'd4, 2'd3},
        {1'b1, 1'b0, 8'h14, 8'h05, 8'd3, 2'd3},
        {1'b1, 1'b1, 8'hA5, 8'h5A, 8'd2, 2'd2},
        {1'b1, 1'b0, 8'h12, 8'h03, 8'd2, 2'd0},
        {1'b0, 1'b0, 8'h11, 8'h02, 8'd1, 2'd0},
        {1'b1, 1'b0, 8'h10, 8'h01, 8'd1, 2'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ev(input logic s, input logic m, input logic [31:0] a, input logic [7:0] y);
        @(negedge clk);
        chk_valid = 1'b1; chk_sbe = s; chk_mbe = m; chk_addr = a; chk_syn = y;
        @(negedge clk);
        chk_valid = 1'b0; chk_sbe = 1'b0; chk_mbe = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 6; a++) chk_reg("R1", 3'(a), 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R10: writable registers read back
        wr(3'd0, 32'hF);
        wr(3'd3, 32'd3);
        chk_reg("R10 ctrl", 3'd0, 32'hF);
        chk_reg("R10 trig", 3'd3, 32'd3);

        // table walk: R2, R3, R5, R6
        for (int i = 0; i < NVEC; i++) begin
            logic [27:0] e;
            e = VEC[i];
            ev(e[27], e[26], {24'h0, e[25:18]}, e[17:10]);
            chk_reg("R2/R6 count", 3'd2, {24'h0, e[9:2]});
            chk_reg("R3/R5 status", 3'd1, {30'h0, e[1:0]});
        end

        // R9: capture from the first reported (multi-bit) access
        chk_reg("R9 addr", 3'd4, 32'hA5);
        chk_reg("R9 syn", 3'd5, 32'h5A);
        check("R8 irq both", {31'b0, irq}, 32'h1);

        // R7: clear only the multi-bit status
        wr(3'd1, 32'h2);
        chk_reg("R7 partial", 3'd1, 32'h1);
        check("R8 irq sbe", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h3);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'hF);
        wr(3'd1, 32'h0);
        chk_reg("R7 write zero", 3'd1, 32'h1);
        wr(3'd1, 32'h1);
        chk_reg("R7 clear", 3'd1, 32'h0);
        check("R8 irq clear", {31'b0, irq}, 32'h0);

        // R9: new capture after clear
        ev(1'b0, 1'b1, 32'h77, 8'h33);
        chk_reg("R5 mbe", 3'd1, 32'h2);
        chk_reg("R9 recap addr", 3'd4, 32'h77);
        chk_reg("R9 recap syn", 3'd5, 32'h33);
        ev(1'b0, 1'b1, 32'h99, 8'h44);
        chk_reg("R9 hold", 3'd4, 32'h77);
        wr(3'd1, 32'h3);

        // R4: zero trigger disables single-bit reporting
        wr(3'd3, 32'd0);
        wr(3'd2, 32'd0);
        for (int k = 0; k < 3; k++) ev(1'b1, 1'b0, 32'h1, 8'h1);
        chk_reg("R4 count", 3'd2, 32'd3);
        chk_reg("R4 status", 3'd1, 32'h0);

        // R2/R3: saturation and match at maximum
        wr(3'd3, 32'd255);
        wr(3'd2, 32'd253);
        ev(1'b1, 1'b0, 32'h2, 8'h2);
        chk_reg("R2 254", 3'd2, 32'd254);
        chk_reg("R3 not yet", 3'd1, 32'h0);
        ev(1'b1, 1'b0, 32'h3, 8'h3);
        chk_reg("R3 match", 3'd1, 32'h1);
        ev(1'b1, 1'b0, 32'h4, 8'h4);
        chk_reg("R2 saturate", 3'd2, 32'd255);
        wr(3'd1, 32'h1);

        // R3: single-bit reporting disabled
        wr(3'd0, 32'hE);
        wr(3'd3, 32'd1);
        wr(3'd2, 32'd0);
        ev(1'b1, 1'b0, 32'h5, 8'h5);
        chk_reg("R3 disabled count", 3'd2, 32'd1);
        chk_reg("R3 disabled", 3'd1, 32'h0);

        // R5: multi-bit reporting disabled
        wr(3'd0, 32'hD);
        ev(1'b0, 1'b1, 32'h6, 8'h6);
        chk_reg("R5 disabled", 3'd1, 32'h0);
        check("R8 idle", {31'b0, irq}, 32'h0);

        finish_run();
    end

endmodule